// File: doc/BRIEF.md
# Per-CPU Interrupt Priority Selector

This block sits between the interrupt distributor's state storage and the per-processor interfaces. For every processor interface it reduces the complete set of interrupt lines (software-generated, private peripheral and shared peripheral) to one winner. The winner is the pending, enabled line with the most urgent priority. The block also computes each processor's running priority from the lines that are currently active. Both results are registered, so they follow a change on any input one clock later.

Shared lines are steered to processors by an 8-bit target byte per line. The block has two routing modes. In the legacy mode the target byte is a processor bitmask. In the extended mode it is a processor number, which lets the distributor address processors beyond the width of the mask. The extended mode is selected by writing one bit of the distributor type register. That register is otherwise read-only, and it reports the configuration and advertises that the extended mode exists. The block also supplies the read value of the banked target register for a requesting processor. In the legacy mode it flags shared lines that have more than one target bit set.

Top module: `ips_prio_sel`

## Requirements
- R1: Lower priority values are more urgent. A candidate beats the current best only with a strictly lower value, so on equal priority the lower interrupt ID wins. The result appears on `win_id_o` one clock edge after the inputs change, and not before.
- R2: Interrupt IDs are assigned in this order: software-generated lines take 0..NUM_SGI-1, private peripheral lines follow, and shared lines start at NUM_SGI+NUM_PPI. With the defaults these ranges are 0..15, 16..31 and 32..63. A CPU with no qualifying line reports ID 1023, and this is also the value after reset.
- R3: A software-generated or private line qualifies for a CPU when that CPU's bank has it pending and enabled. A software-generated line counts as pending when either of its two pending stores has it set.
- R4: In legacy mode a shared line qualifies for CPU c when it is pending and enabled and bit c of its target byte is 1.
- R5: In extended mode a shared line qualifies for CPU c when it is pending and enabled and its target byte equals c.
- R6: A CPU whose interface enable is 0 reports ID 1023 and running priority 0xFF from the next edge on.
- R7: The running priority of a CPU is the minimum priority over its active lines, or 0xFF when none are active. Its active lines are: software-generated lines active in either store, its private lines, and shared lines routed to it under the current mode's target rule.
- R8: `type_rd_o` reads ((NUM_CPU-1) << 5) | (lines/32 - 1) | 0x100, which is 0x161 with the defaults. Bit 8 advertises the extended mode. Writing the register does not change this value.
- R9: A type-register write sets the extended mode when bit 9 (0x200) of the written word is 1 and clears it when that bit is 0. `ext_mode_o` shows the new mode after the write edge. Routing in `win_id_o` uses the new mode one edge later. The mode is 0 after reset.
- R10: `tgt_rd_o` holds the requesting CPU's byte repeated in all four byte lanes. That byte is 1 << cpu in legacy mode and the CPU number in extended mode.
- R11: `tgt_err_o` is 1 when the mode is legacy and some pending shared line has more than one target bit set. It is always 0 in extended mode.
- R12: Priorities of software-generated and private lines are banked, one byte per CPU per line. Shared-line priorities are one byte per line, common to all CPUs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_en_i | input | NUM_CPU | Interface enable per CPU |
| prv_en_i | input | NUM_CPU*(NUM_SGI+NUM_PPI) | Banked enable of private IDs, CPU-major |
| sgi_pend_lgc_i | input | NUM_CPU*NUM_SGI | Software-generated pending, first store |
| sgi_pend_ext_i | input | NUM_CPU*NUM_SGI | Software-generated pending, second store |
| sgi_act_lgc_i | input | NUM_CPU*NUM_SGI | Software-generated active, first store |
| sgi_act_ext_i | input | NUM_CPU*NUM_SGI | Software-generated active, second store |
| ppi_pend_i | input | NUM_CPU*NUM_PPI | Private peripheral pending |
| ppi_act_i | input | NUM_CPU*NUM_PPI | Private peripheral active |
| prv_prio_i | input | NUM_CPU*(NUM_SGI+NUM_PPI)*8 | Banked priority bytes of private IDs |
| spi_pend_i | input | NUM_SPI | Shared line pending |
| spi_en_i | input | NUM_SPI | Shared line enable |
| spi_act_i | input | NUM_SPI | Shared line active |
| spi_prio_i | input | NUM_SPI*8 | Shared line priority bytes |
| spi_tgt_i | input | NUM_SPI*8 | Shared line target bytes |
| type_wr_i | input | 1 | Write strobe of the type register |
| type_wr_mode_i | input | 1 | Bit 9 of the word written to the type register |
| rd_cpu_i | input | CPU_W | CPU requesting the target-register read |
| type_rd_o | output | 32 | Type register read value |
| tgt_rd_o | output | 32 | Banked target register read value |
| ext_mode_o | output | 1 | Extended routing mode is on |
| tgt_err_o | output | 1 | Multi-target shared line in legacy mode |
| win_id_o | output | NUM_CPU*10 | Winning ID per CPU |
| run_prio_o | output | NUM_CPU*8 | Running priority per CPU |

## Verification
`win_id_o` and `run_prio_o` are due one edge after their inputs change. The bench drives on the falling edge and samples on the following falling edge, and in one case it also samples before the edge to confirm that the old value still holds. A mode write shows on `ext_mode_o` one edge after the write, and the bench waits a further edge before it compares routing results. `type_rd_o`, `tgt_rd_o` and `tgt_err_o` are combinational, so they are sampled shortly after the inputs settle. Every comparison uses a model that scans IDs in ascending order.

// File: rtl/ips_pkg.sv
// Package: constants shared by the interrupt priority selector.
// Assumes 8-bit priorities and 8-bit target bytes.
package ips_pkg;
    localparam int            ID_W         = 10;
    localparam int            PRIO_W       = 8;
    localparam int            TGT_W        = 8;
    localparam logic [9:0]    SPURIOUS_ID  = 10'd1023;
    localparam logic [7:0]    PRIO_IDLE    = 8'hFF;
    localparam int            TYPE_CPU_LSB = 5;
    localparam logic [31:0]   TYPE_AVAIL   = 32'h0000_0100;
endpackage

// File: rtl/ips_win_tree.sv
// Module: balanced comparison tree returning the index of the most urgent
// valid input. Ties go to the left (lower) index. Pure combinational.
// Assumes inputs are ordered by interrupt ID.
module ips_win_tree #(
    parameter int N_IN   = 64,
    parameter int PRIO_W = 8,
    parameter int IDX_W  = (N_IN < 2) ? 1 : $clog2(N_IN)
) (
    input  logic [N_IN-1:0]        vld_i,
    input  logic [N_IN*PRIO_W-1:0] prio_i,
    output logic                   best_vld_o,
    output logic [IDX_W-1:0]       best_idx_o
);
    localparam int LEAVES = 1 << IDX_W;
    localparam int NODES  = 2 * LEAVES - 1;

    logic [PRIO_W:0]  key [NODES];
    logic [IDX_W-1:0] idx [NODES];

    // Fill leaves with {invalid, priority} keys and reduce pairwise to the root.
    always_comb begin
        for (int n = 0; n < NODES; n++) begin
            key[n] = '1;
            idx[n] = '0;
        end
        for (int k = 0; k < LEAVES; k++) begin
            if (k < N_IN) begin
                key[LEAVES-1+k] = {~vld_i[k], prio_i[k*PRIO_W +: PRIO_W]};
            end
            idx[LEAVES-1+k] = IDX_W'(k);
        end
        for (int i = LEAVES - 2; i >= 0; i--) begin
            if (key[2*i+1] <= key[2*i+2]) begin
                key[i] = key[2*i+1];
                idx[i] = idx[2*i+1];
            end else begin
                key[i] = key[2*i+2];
                idx[i] = idx[2*i+2];
            end
        end
    end

    assign best_vld_o = ~key[0][PRIO_W];
    assign best_idx_o = idx[0];
endmodule

// File: rtl/ips_min_tree.sv
// Module: balanced minimum tree over priorities of valid inputs.
// Returns all ones when no input is valid. Pure combinational.
module ips_min_tree #(
    parameter int N_IN   = 64,
    parameter int PRIO_W = 8
) (
    input  logic [N_IN-1:0]        vld_i,
    input  logic [N_IN*PRIO_W-1:0] prio_i,
    output logic [PRIO_W-1:0]      min_o
);
    localparam int LVL_W  = (N_IN < 2) ? 1 : $clog2(N_IN);
    localparam int LEAVES = 1 << LVL_W;
    localparam int NODES  = 2 * LEAVES - 1;

    logic [PRIO_W-1:0] val [NODES];

    // Load masked priorities and keep the smaller of each pair.
    always_comb begin
        for (int n = 0; n < NODES; n++) begin
            val[n] = '1;
        end
        for (int k = 0; k < N_IN; k++) begin
            if (vld_i[k]) begin
                val[LEAVES-1+k] = prio_i[k*PRIO_W +: PRIO_W];
            end
        end
        for (int i = LEAVES - 2; i >= 0; i--) begin
            val[i] = (val[2*i+1] <= val[2*i+2]) ? val[2*i+1] : val[2*i+2];
        end
    end

    assign min_o = val[0];
endmodule

// File: rtl/ips_mode_ctl.sv
// Module: routing-mode register, type/target read values, shared-line
// target matching per CPU and the legacy multi-target error flag.
// Assumes target bytes are TGT_W bits wide.
module ips_mode_ctl
    import ips_pkg::*;
#(
    parameter int NUM_CPU   = 4,
    parameter int NUM_SPI   = 32,
    parameter int NUM_LINES = 64,
    parameter int CPU_W     = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       type_wr_i,
    input  logic                       type_wr_mode_i,
    input  logic [CPU_W-1:0]           rd_cpu_i,
    input  logic [NUM_SPI-1:0]         spi_pend_i,
    input  logic [NUM_SPI*TGT_W-1:0]   spi_tgt_i,
    output logic [31:0]                type_rd_o,
    output logic [31:0]                tgt_rd_o,
    output logic                       ext_mode_o,
    output logic                       tgt_err_o,
    output logic [NUM_CPU*NUM_SPI-1:0] spi_match_o
);
    localparam logic [31:0] TYPE_VAL = (32'(NUM_CPU - 1) << TYPE_CPU_LSB)
                                     | 32'(NUM_LINES / 32 - 1) | TYPE_AVAIL;

    logic              ext_q;
    logic [TGT_W-1:0]  own_byte;
    logic [NUM_SPI-1:0] multi;

    // Mode register: loaded from bit 9 of each type-register write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ext_q <= 1'b0;
        end else if (type_wr_i) begin
            ext_q <= type_wr_mode_i;
        end
    end

    // Banked target read byte: CPU number or one-hot mask.
    always_comb begin
        own_byte = ext_q ? TGT_W'(rd_cpu_i) : (TGT_W'(1) << rd_cpu_i);
    end

    genvar s, c;
    generate
        for (s = 0; s < NUM_SPI; s++) begin : g_spi
            logic [TGT_W-1:0] tbyte;
            assign tbyte    = spi_tgt_i[s*TGT_W +: TGT_W];
            assign multi[s] = spi_pend_i[s] & (|(tbyte & (tbyte - 1'b1)));
            for (c = 0; c < NUM_CPU; c++) begin : g_cpu
                logic legacy_hit;
                if (c < TGT_W) begin : g_bit
                    assign legacy_hit = tbyte[c];
                end else begin : g_none
                    assign legacy_hit = 1'b0;
                end
                assign spi_match_o[c*NUM_SPI+s] =
                    ext_q ? (tbyte == TGT_W'(c)) : legacy_hit;
            end
        end
    endgenerate

    assign type_rd_o  = TYPE_VAL;
    assign tgt_rd_o   = {4{own_byte}};
    assign ext_mode_o = ext_q;
    assign tgt_err_o  = ~ext_q & (|multi);
endmodule

// File: rtl/ips_cpu_lane.sv
// Module: one CPU's candidate builder plus winner and running-priority
// registers. Assumes private IDs precede shared IDs in the input order.
module ips_cpu_lane
    import ips_pkg::*;
#(
    parameter int NUM_SGI = 16,
    parameter int NUM_PPI = 16,
    parameter int NUM_SPI = 32
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           cpu_en_i,
    input  logic [NUM_SGI+NUM_PPI-1:0]     prv_en_i,
    input  logic [NUM_SGI-1:0]             sgi_pl_i,
    input  logic [NUM_SGI-1:0]             sgi_pe_i,
    input  logic [NUM_SGI-1:0]             sgi_al_i,
    input  logic [NUM_SGI-1:0]             sgi_ae_i,
    input  logic [NUM_PPI-1:0]             ppi_p_i,
    input  logic [NUM_PPI-1:0]             ppi_a_i,
    input  logic [(NUM_SGI+NUM_PPI)*PRIO_W-1:0] prv_prio_i,
    input  logic [NUM_SPI-1:0]             spi_pend_i,
    input  logic [NUM_SPI-1:0]             spi_en_i,
    input  logic [NUM_SPI-1:0]             spi_act_i,
    input  logic [NUM_SPI-1:0]             spi_match_i,
    input  logic [NUM_SPI*PRIO_W-1:0]      spi_prio_i,
    output logic [ID_W-1:0]                win_id_o,
    output logic [PRIO_W-1:0]              run_prio_o
);
    localparam int NUM_PRV   = NUM_SGI + NUM_PPI;
    localparam int NUM_LINES = NUM_PRV + NUM_SPI;
    localparam int TREE_W    = (NUM_LINES < 2) ? 1 : $clog2(NUM_LINES);

    logic [NUM_LINES-1:0]        cand_v;
    logic [NUM_LINES-1:0]        act_v;
    logic [NUM_LINES*PRIO_W-1:0] line_p;
    logic                        best_vld;
    logic [TREE_W-1:0]           best_idx;
    logic [PRIO_W-1:0]           act_min;

    genvar j;
    generate
        for (j = 0; j < NUM_LINES; j++) begin : g_line
            if (j < NUM_SGI) begin : g_sgi
                assign cand_v[j] = (sgi_pl_i[j] | sgi_pe_i[j]) & prv_en_i[j];
                assign act_v[j]  = sgi_al_i[j] | sgi_ae_i[j];
                assign line_p[j*PRIO_W +: PRIO_W] = prv_prio_i[j*PRIO_W +: PRIO_W];
            end else if (j < NUM_PRV) begin : g_ppi
                localparam int K = j - NUM_SGI;
                assign cand_v[j] = ppi_p_i[K] & prv_en_i[j];
                assign act_v[j]  = ppi_a_i[K];
                assign line_p[j*PRIO_W +: PRIO_W] = prv_prio_i[j*PRIO_W +: PRIO_W];
            end else begin : g_spi
                localparam int K = j - NUM_PRV;
                assign cand_v[j] = spi_pend_i[K] & spi_en_i[K] & spi_match_i[K];
                assign act_v[j]  = spi_act_i[K] & spi_match_i[K];
                assign line_p[j*PRIO_W +: PRIO_W] = spi_prio_i[K*PRIO_W +: PRIO_W];
            end
        end
    endgenerate

    ips_win_tree #(.N_IN(NUM_LINES), .PRIO_W(PRIO_W), .IDX_W(TREE_W)) u_win (
        .vld_i      (cand_v),
        .prio_i     (line_p),
        .best_vld_o (best_vld),
        .best_idx_o (best_idx)
    );

    ips_min_tree #(.N_IN(NUM_LINES), .PRIO_W(PRIO_W)) u_run (
        .vld_i  (act_v),
        .prio_i (line_p),
        .min_o  (act_min)
    );

    // Output registers: winner or spurious, running priority or idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_id_o   <= SPURIOUS_ID;
            run_prio_o <= PRIO_IDLE;
        end else begin
            win_id_o   <= (cpu_en_i && best_vld) ? ID_W'(best_idx) : SPURIOUS_ID;
            run_prio_o <= cpu_en_i ? act_min : PRIO_IDLE;
        end
    end
endmodule

// File: rtl/ips_prio_sel.sv
// Module: top of the per-CPU interrupt priority selector. Routes shared
// lines by mode and runs one selection lane per CPU interface.
// Assumes NUM_CPU <= 256 so that a CPU number fits a target byte.
module ips_prio_sel
    import ips_pkg::*;
#(
    parameter int NUM_CPU = 4,
    parameter int NUM_SGI = 16,
    parameter int NUM_PPI = 16,
    parameter int NUM_SPI = 32,
    localparam int NUM_PRV   = NUM_SGI + NUM_PPI,
    localparam int NUM_LINES = NUM_PRV + NUM_SPI,
    localparam int CPU_W     = (NUM_CPU < 2) ? 1 : $clog2(NUM_CPU)
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [NUM_CPU-1:0]              cpu_en_i,
    input  logic [NUM_CPU*NUM_PRV-1:0]      prv_en_i,
    input  logic [NUM_CPU*NUM_SGI-1:0]      sgi_pend_lgc_i,
    input  logic [NUM_CPU*NUM_SGI-1:0]      sgi_pend_ext_i,
    input  logic [NUM_CPU*NUM_SGI-1:0]      sgi_act_lgc_i,
    input  logic [NUM_CPU*NUM_SGI-1:0]      sgi_act_ext_i,
    input  logic [NUM_CPU*NUM_PPI-1:0]      ppi_pend_i,
    input  logic [NUM_CPU*NUM_PPI-1:0]      ppi_act_i,
    input  logic [NUM_CPU*NUM_PRV*8-1:0]    prv_prio_i,
    input  logic [NUM_SPI-1:0]              spi_pend_i,
    input  logic [NUM_SPI-1:0]              spi_en_i,
    input  logic [NUM_SPI-1:0]              spi_act_i,
    input  logic [NUM_SPI*8-1:0]            spi_prio_i,
    input  logic [NUM_SPI*8-1:0]            spi_tgt_i,
    input  logic                            type_wr_i,
    input  logic                            type_wr_mode_i,
    input  logic [CPU_W-1:0]                rd_cpu_i,
    output logic [31:0]                     type_rd_o,
    output logic [31:0]                     tgt_rd_o,
    output logic                            ext_mode_o,
    output logic                            tgt_err_o,
    output logic [NUM_CPU*10-1:0]           win_id_o,
    output logic [NUM_CPU*8-1:0]            run_prio_o
);
    logic [NUM_CPU*NUM_SPI-1:0] spi_match;

    ips_mode_ctl #(
        .NUM_CPU(NUM_CPU), .NUM_SPI(NUM_SPI),
        .NUM_LINES(NUM_LINES), .CPU_W(CPU_W)
    ) u_mode (
        .clk            (clk),
        .rst_n          (rst_n),
        .type_wr_i      (type_wr_i),
        .type_wr_mode_i (type_wr_mode_i),
        .rd_cpu_i       (rd_cpu_i),
        .spi_pend_i     (spi_pend_i),
        .spi_tgt_i      (spi_tgt_i),
        .type_rd_o      (type_rd_o),
        .tgt_rd_o       (tgt_rd_o),
        .ext_mode_o     (ext_mode_o),
        .tgt_err_o      (tgt_err_o),
        .spi_match_o    (spi_match)
    );

    genvar c;
    generate
        for (c = 0; c < NUM_CPU; c++) begin : g_lane
            ips_cpu_lane #(
                .NUM_SGI(NUM_SGI), .NUM_PPI(NUM_PPI), .NUM_SPI(NUM_SPI)
            ) u_lane (
                .clk         (clk),
                .rst_n       (rst_n),
                .cpu_en_i    (cpu_en_i[c]),
                .prv_en_i    (prv_en_i[c*NUM_PRV +: NUM_PRV]),
                .sgi_pl_i    (sgi_pend_lgc_i[c*NUM_SGI +: NUM_SGI]),
                .sgi_pe_i    (sgi_pend_ext_i[c*NUM_SGI +: NUM_SGI]),
                .sgi_al_i    (sgi_act_lgc_i[c*NUM_SGI +: NUM_SGI]),
                .sgi_ae_i    (sgi_act_ext_i[c*NUM_SGI +: NUM_SGI]),
                .ppi_p_i     (ppi_pend_i[c*NUM_PPI +: NUM_PPI]),
                .ppi_a_i     (ppi_act_i[c*NUM_PPI +: NUM_PPI]),
                .prv_prio_i  (prv_prio_i[c*NUM_PRV*8 +: NUM_PRV*8]),
                .spi_pend_i  (spi_pend_i),
                .spi_en_i    (spi_en_i),
                .spi_act_i   (spi_act_i),
                .spi_match_i (spi_match[c*NUM_SPI +: NUM_SPI]),
                .spi_prio_i  (spi_prio_i),
                .win_id_o    (win_id_o[c*10 +: 10]),
                .run_prio_o  (run_prio_o[c*8 +: 8])
            );
        end
    endgenerate
endmodule

// File: rtl/ips_prio_sel_chk.sv
// Module: property checker for ips_prio_sel, attached with bind below.
module ips_prio_sel_chk #(
    parameter int NUM_CPU = 4,
    parameter int NUM_SGI = 16,
    parameter int NUM_PPI = 16,
    parameter int NUM_SPI = 32
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic [NUM_CPU-1:0]         cpu_en_i,
    input logic [NUM_CPU*NUM_SGI-1:0] sgi_act_lgc_i,
    input logic [NUM_CPU*NUM_SGI-1:0] sgi_act_ext_i,
    input logic [NUM_CPU*NUM_PPI-1:0] ppi_act_i,
    input logic [NUM_SPI-1:0]         spi_act_i,
    input logic                       type_wr_i,
    input logic                       type_wr_mode_i,
    input logic [31:0]                tgt_rd_o,
    input logic                       ext_mode_o,
    input logic                       tgt_err_o,
    input logic [NUM_CPU*10-1:0]      win_id_o,
    input logic [NUM_CPU*8-1:0]       run_prio_o
);
    localparam int NUM_LINES = NUM_SGI + NUM_PPI + NUM_SPI;

    logic any_act;
    assign any_act = (|sgi_act_lgc_i) | (|sgi_act_ext_i) | (|ppi_act_i) | (|spi_act_i);

    AST_MODE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        type_wr_i |=> (ext_mode_o == $past(type_wr_mode_i))); // R9
    AST_MODE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !type_wr_i |=> $stable(ext_mode_o)); // R9
    AST_TGT_LANES: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_rd_o[31:24] == tgt_rd_o[7:0]) && (tgt_rd_o[23:16] == tgt_rd_o[7:0])
        && (tgt_rd_o[15:8] == tgt_rd_o[7:0])); // R10
    AST_TGT_LEGACY_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_mode_o |-> ($countones(tgt_rd_o[7:0]) <= 1)); // R10
    AST_NO_ERR_EXT: assert property (@(posedge clk) disable iff (!rst_n)
        ext_mode_o |-> !tgt_err_o); // R11

    genvar c;
    generate
        for (c = 0; c < NUM_CPU; c++) begin : g_cpu
            AST_OFF_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
                !cpu_en_i[c] |=> (win_id_o[c*10 +: 10] == 10'd1023)
                                 && (run_prio_o[c*8 +: 8] == 8'hFF)); // R6
            AST_WIN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
                (win_id_o[c*10 +: 10] == 10'd1023)
                || (win_id_o[c*10 +: 10] < 10'(NUM_LINES))); // R2
            AST_IDLE_RUNPRIO: assert property (@(posedge clk) disable iff (!rst_n)
                !any_act |=> (run_prio_o[c*8 +: 8] == 8'hFF)); // R7
        end
    endgenerate
endmodule

bind ips_prio_sel ips_prio_sel_chk #(
    .NUM_CPU(NUM_CPU), .NUM_SGI(NUM_SGI), .NUM_PPI(NUM_PPI), .NUM_SPI(NUM_SPI)
) chk_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .cpu_en_i       (cpu_en_i),
    .sgi_act_lgc_i  (sgi_act_lgc_i),
    .sgi_act_ext_i  (sgi_act_ext_i),
    .ppi_act_i      (ppi_act_i),
    .spi_act_i      (spi_act_i),
    .type_wr_i      (type_wr_i),
    .type_wr_mode_i (type_wr_mode_i),
    .tgt_rd_o       (tgt_rd_o),
    .ext_mode_o     (ext_mode_o),
    .tgt_err_o      (tgt_err_o),
    .win_id_o       (win_id_o),
    .run_prio_o     (run_prio_o)
);

// File: tb/ips_prio_sel_tb_top.sv
// Bench: sweeps every ID on every CPU, then randomized patterns in both
// modes against an ascending-scan model, plus directed corner cases.
module ips_prio_sel_tb_top;
    localparam int NC = 4, NS = 16, NP = 16, NX = 32;
    localparam int NPRV = NS + NP, NL = NPRV + NX;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic [NC-1:0]        cpu_en;
    logic [NC*NPRV-1:0]   prv_en;
    logic [NC*NS-1:0]     sgi_pl, sgi_pe, sgi_al, sgi_ae;
    logic [NC*NP-1:0]     ppi_p, ppi_a;
    logic [NC*NPRV*8-1:0] prv_prio;
    logic [NX-1:0]        spi_p, spi_e, spi_a;
    logic [NX*8-1:0]      spi_prio, spi_tgt;
    logic                 type_wr, type_mode;
    logic [1:0]           rd_cpu;
    logic [31:0]          type_rd, tgt_rd;
    logic                 ext_mode, tgt_err;
    logic [NC*10-1:0]     win_id;
    logic [NC*8-1:0]      run_prio;

    ips_prio_sel dut_i (
        .clk(clk), .rst_n(rst_n), .cpu_en_i(cpu_en), .prv_en_i(prv_en),
        .sgi_pend_lgc_i(sgi_pl), .sgi_pend_ext_i(sgi_pe),
        .sgi_act_lgc_i(sgi_al), .sgi_act_ext_i(sgi_ae),
        .ppi_pend_i(ppi_p), .ppi_act_i(ppi_a), .prv_prio_i(prv_prio),
        .spi_pend_i(spi_p), .spi_en_i(spi_e), .spi_act_i(spi_a),
        .spi_prio_i(spi_prio), .spi_tgt_i(spi_tgt),
        .type_wr_i(type_wr), .type_wr_mode_i(type_mode), .rd_cpu_i(rd_cpu),
        .type_rd_o(type_rd), .tgt_rd_o(tgt_rd), .ext_mode_o(ext_mode),
        .tgt_err_o(tgt_err), .win_id_o(win_id), .run_prio_o(run_prio)
    );

    int  n_chk = 0;
    int  n_err = 0;
    bit  mode_ext = 1'b0;
    bit  finished = 1'b0;

    task automatic check(string req, string what, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic bit m_match(int c, int s);
        logic [7:0] t;
        t = spi_tgt[s*8 +: 8];
        return mode_ext ? (t == 8'(c)) : ((c < 8) && t[c]);
    endfunction

    function automatic int m_win(int c);
        int best, id, p;
        bit v;
        best = 256; id = 1023;
        if (!cpu_en[c]) return 1023;
        for (int j = 0; j < NL; j++) begin
            if (j < NS) begin
                v = (sgi_pl[c*NS+j] | sgi_pe[c*NS+j]) & prv_en[c*NPRV+j];
                p = int'(prv_prio[(c*NPRV+j)*8 +: 8]);
            end else if (j < NPRV) begin
                v = ppi_p[c*NP+j-NS] & prv_en[c*NPRV+j];
                p = int'(prv_prio[(c*NPRV+j)*8 +: 8]);
            end else begin
                v = spi_p[j-NPRV] & spi_e[j-NPRV] & m_match(c, j-NPRV);
                p = int'(spi_prio[(j-NPRV)*8 +: 8]);
            end
            if (v && p < best) begin best = p; id = j; end
        end
        return id;
    endfunction

    function automatic int m_run(int c);
        int m, p;
        bit v;
        m = 255;
        if (!cpu_en[c]) return 255;
        for (int j = 0; j < NL; j++) begin
            if (j < NS) begin
                v = sgi_al[c*NS+j] | sgi_ae[c*NS+j];
                p = int'(prv_prio[(c*NPRV+j)*8 +: 8]);
            end else if (j < NPRV) begin
                v = ppi_a[c*NP+j-NS];
                p = int'(prv_prio[(c*NPRV+j)*8 +: 8]);
            end else begin
                v = spi_a[j-NPRV] & m_match(c, j-NPRV);
                p = int'(spi_prio[(j-NPRV)*8 +: 8]);
            end
            if (v && p < m) m = p;
        end
        return m;
    endfunction

    function automatic bit m_err();
        logic [7:0] t;
        if (mode_ext) return 1'b0;
        for (int s = 0; s < NX; s++) begin
            t = spi_tgt[s*8 +: 8];
            if (spi_p[s] && $countones(t) > 1) return 1'b1;
        end
        return 1'b0;
    endfunction

    task automatic clear_all();
        cpu_en = '1; prv_en = '0; sgi_pl = '0; sgi_pe = '0; sgi_al = '0; sgi_ae = '0;
        ppi_p = '0; ppi_a = '0; prv_prio = '0; spi_p = '0; spi_e = '0; spi_a = '0;
        spi_prio = '0; spi_tgt = '0;
    endtask

    task automatic settle();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic write_mode(bit m);
        type_wr = 1'b1; type_mode = m;
        @(posedge clk);
        @(negedge clk);
        type_wr = 1'b0; type_mode = 1'b0;
        mode_ext = m;
    endtask

    task automatic check_model(string req);
        for (int c = 0; c < NC; c++) begin
            check(req, $sformatf("win cpu%0d", c), longint'(win_id[c*10 +: 10]), longint'(m_win(c)));
            check("R7", $sformatf("run cpu%0d", c), longint'(run_prio[c*8 +: 8]), longint'(m_run(c)));
        end
        check("R11", "tgt_err", longint'(tgt_err), longint'(m_err()));
    endtask

    task automatic set_prv_prio(int c, int j, int p);
        prv_prio[(c*NPRV+j)*8 +: 8] = 8'(p);
    endtask

    initial begin
        type_wr = 1'b0; type_mode = 1'b0; rd_cpu = '0;
        clear_all();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Reset state: R2 spurious, R6-style idle priority, R9 mode cleared, R8 type.
        for (int c = 0; c < NC; c++) begin
            check("R2", "reset win", longint'(win_id[c*10 +: 10]), 1023);
            check("R7", "reset run", longint'(run_prio[c*8 +: 8]), 255);
        end
        check("R9", "reset mode", longint'(ext_mode), 0);
        check("R8", "type read", longint'(type_rd), 64'h161);

        // R1 latency: change is not visible before the edge.
        sgi_pl[0] = 1'b1; prv_en[0] = 1'b1;
        #2;
        check("R1", "before edge", longint'(win_id[9:0]), 1023);
        @(negedge clk);
        settle();
        check("R1", "after edge", longint'(win_id[9:0]), 0);

        // Sweep: every ID alone on every CPU, legacy mode (R2, R3, R4).
        for (int c = 0; c < NC; c++) begin
            for (int j = 0; j < NL; j++) begin
                clear_all();
                if (j < NS) begin
                    if (j % 2 == 1) sgi_pe[c*NS+j] = 1'b1; else sgi_pl[c*NS+j] = 1'b1;
                    prv_en[c*NPRV+j] = 1'b1;
                end else if (j < NPRV) begin
                    ppi_p[c*NP+j-NS] = 1'b1; prv_en[c*NPRV+j] = 1'b1;
                end else begin
                    spi_p[j-NPRV] = 1'b1; spi_e[j-NPRV] = 1'b1;
                    spi_tgt[(j-NPRV)*8 +: 8] = 8'(1 << c);
                end
                settle();
                check("R2", $sformatf("sweep id%0d cpu%0d", j, c), longint'(win_id[c*10 +: 10]), longint'(j));
                check_model(j < NPRV ? "R3" : "R4");
            end
        end

        // Pending but not enabled stays spurious (R3, R4).
        clear_all();
        sgi_pl[5] = 1'b1; ppi_p[2] = 1'b1; spi_p[3] = 1'b1; spi_tgt[3*8 +: 8] = 8'h01;
        settle();
        check("R3", "disabled private", longint'(win_id[9:0]), 1023);

        // Tie on priority: lower ID wins (R1).
        clear_all();
        spi_p[5:4] = 2'b11; spi_e[5:4] = 2'b11;
        spi_tgt[4*8 +: 8] = 8'h01; spi_tgt[5*8 +: 8] = 8'h01;
        spi_prio[4*8 +: 8] = 8'h22; spi_prio[5*8 +: 8] = 8'h22;
        settle();
        check("R1", "tie", longint'(win_id[9:0]), 36);
        spi_prio[5*8 +: 8] = 8'h21;
        settle();
        check("R1", "strictly lower", longint'(win_id[9:0]), 37);

        // Banked private priorities vs global shared ones (R12).
        clear_all();
        ppi_p[0*NP+4] = 1'b1; ppi_p[1*NP+4] = 1'b1;
        prv_en[0*NPRV+20] = 1'b1; prv_en[1*NPRV+20] = 1'b1;
        set_prv_prio(0, 20, 8'h10); set_prv_prio(1, 20, 8'h30);
        spi_p[1] = 1'b1; spi_e[1] = 1'b1; spi_tgt[1*8 +: 8] = 8'h01; spi_prio[1*8 +: 8] = 8'h20;
        spi_p[2] = 1'b1; spi_e[2] = 1'b1; spi_tgt[2*8 +: 8] = 8'h02; spi_prio[2*8 +: 8] = 8'h20;
        settle();
        check("R12", "cpu0 banked", longint'(win_id[9:0]), 20);
        check("R12", "cpu1 banked", longint'(win_id[19:10]), 34);

        // Running priority from both SGI stores, PPI and routed SPI (R7).
        clear_all();
        sgi_ae[3] = 1'b1; set_prv_prio(0, 3, 8'h40);
        ppi_a[2] = 1'b1;  set_prv_prio(0, 18, 8'h50);
        spi_a[3] = 1'b1;  spi_tgt[3*8 +: 8] = 8'h01; spi_prio[3*8 +: 8] = 8'h30;
        settle();
        check("R7", "run cpu0", longint'(run_prio[7:0]), 8'h30);
        check("R7", "run cpu1 idle", longint'(run_prio[15:8]), 8'hFF);
        spi_a[3] = 1'b0;
        settle();
        check("R7", "run cpu0 sgi ext", longint'(run_prio[7:0]), 8'h40);

        // Disabled interface (R6).
        clear_all();
        sgi_pl[2*NS+1] = 1'b1; prv_en[2*NPRV+1] = 1'b1; sgi_al[2*NS+1] = 1'b1;
        cpu_en[2] = 1'b0;
        settle();
        check("R6", "off win", longint'(win_id[29:20]), 1023);
        check("R6", "off run", longint'(run_prio[23:16]), 255);

        // Multi-target shared line in legacy mode (R4, R11).
        clear_all();
        spi_p[8] = 1'b1; spi_e[8] = 1'b1; spi_tgt[8*8 +: 8] = 8'h03;
        settle();
        check("R4", "legacy cpu0", longint'(win_id[9:0]), 40);
        check("R4", "legacy cpu1", longint'(win_id[19:10]), 40);
        check("R4", "legacy cpu3", longint'(win_id[39:30]), 1023);
        check("R11", "legacy err", longint'(tgt_err), 1);

        // Mode write and read-backs (R8, R9, R10).
        for (int c = 0; c < NC; c++) begin
            rd_cpu = 2'(c); #1;
            check("R10", "legacy tgt read", longint'(tgt_rd), longint'({4{8'(1 << c)}}));
        end
        write_mode(1'b1);
        check("R9", "mode set", longint'(ext_mode), 1);
        check("R8", "type after write", longint'(type_rd), 64'h161);
        check("R11", "ext err", longint'(tgt_err), 0);
        for (int c = 0; c < NC; c++) begin
            rd_cpu = 2'(c); #1;
            check("R10", "ext tgt read", longint'(tgt_rd), longint'({4{8'(c)}}));
        end
        settle();
        check("R5", "ext cpu3", longint'(win_id[39:30]), 40);
        check("R5", "ext cpu0", longint'(win_id[9:0]), 1023);
        write_mode(1'b0);
        check("R9", "mode cleared", longint'(ext_mode), 0);

        // Randomized patterns, mode switched every 50 iterations (R1..R12).
        for (int it = 0; it < 300; it++) begin
            if (it % 50 == 0) write_mode(bit'((it / 50) % 2));
            cpu_en = 4'($urandom) | 4'b0011;
            for (int b = 0; b < NC*NPRV; b++) begin
                prv_en[b] = ($urandom % 4) != 0;
                prv_prio[b*8 +: 8] = 8'($urandom % 4);
            end
            for (int b = 0; b < NC*NS; b++) begin
                sgi_pl[b] = ($urandom % 8) == 0; sgi_pe[b] = ($urandom % 8) == 0;
                sgi_al[b] = ($urandom % 8) == 0; sgi_ae[b] = ($urandom % 8) == 0;
            end
            for (int b = 0; b < NC*NP; b++) begin
                ppi_p[b] = ($urandom % 8) == 0; ppi_a[b] = ($urandom % 8) == 0;
            end
            for (int s = 0; s < NX; s++) begin
                spi_p[s] = ($urandom % 3) == 0; spi_e[s] = ($urandom % 4) != 0;
                spi_a[s] = ($urandom % 6) == 0;
                spi_prio[s*8 +: 8] = 8'($urandom % 4);
                spi_tgt[s*8 +: 8] = mode_ext ? 8'($urandom % 6) : 8'($urandom & $urandom);
            end
            settle();
            check_model(mode_ext ? "R5" : "R1");
        end

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule